// File: doc/BRIEF.md
# DRAM Refresh Counter Test-Cycle Controller

This block is the device-side control logic of a small DRAM array model. It watches four active-low strobes (row strobe, column strobe, write enable, output enable). It samples them on a system clock and finds their edges internally. From those edges it decodes four kinds of cycle: normal addressed accesses, refresh cycles where the column strobe leads the row strobe, refresh cycles that use the row strobe only, and the refresh counter test cycle.

A 10-bit internal refresh counter selects a row. A refresh where the column strobe leads advances the counter when the row strobe rises. A refresh that uses the row strobe only loads the counter from the address pins, so a test sequence can start from a known row. The counter test cycle begins as a column-strobe-first refresh. If the column strobe rises and then falls a second time while the row strobe is still low, the cycle becomes an addressed access. The row comes from the counter and the column is taken from the pins at that second fall. The access can be a write, a read, or a read-modify-write. This lets a tester walk every row through the counter and compare the results with normal accesses.

The storage is a reduced synchronous array. It holds every row but keeps only the low column bits. The data output is modelled as a value plus an active-high drive enable, which stands in for a high-impedance pin.

Top module: `dram_cbr_test_ctrl`

## Requirements
- R1: After reset the refresh counter is 0 and `dq_oe` is low.
- R2: A cycle in which `cas_n` is already low when `ras_n` falls is a refresh. It accesses no memory. It advances the counter by one, modulo 1024, when `ras_n` rises.
- R3: A cycle in which `ras_n` falls with `cas_n` high, and `ras_n` rises with no `cas_n` fall in between, loads the counter with the address sampled when `ras_n` fell.
- R4: In a normal cycle the row is taken from `addr` when `ras_n` falls and the column when `cas_n` falls. If `we_n` is low at that `cas_n` fall, `din` is written to that location.
- R5: In a normal cycle with `we_n` high at the `cas_n` fall, a read phase starts. While `oe_n` is low, `dq_oe` is high and `dq_out` shows the stored data.
- R6: In a refresh cycle, if `cas_n` rises and then falls again while `ras_n` stays low, an access takes place. Its row is the counter and its column is `addr` at the second fall. With `we_n` low it writes `din`.
- R7: A test-cycle access with `we_n` high and `oe_n` low drives the data stored at the counter row.
- R8: A fall of `we_n` during a read phase writes `din` to the same location and ends the read phase, so `dq_oe` goes low.
- R9: Test cycles also advance the counter when `ras_n` rises. The counter wraps from row 1023 to row 0.
- R10: `dq_oe` is low whenever `oe_n` is high. It is also low once `ras_n` has been high for a sampled cycle.
- R11: The array keeps only the low `MEM_COL_W` column bits. With the default of 1, columns 0 and 2 are the same location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| ras_n | input | 1 | Active-low row strobe |
| cas_n | input | 1 | Active-low column strobe |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | ROW_W | Multiplexed row/column address |
| din | input | DW | Write data |
| dq_out | output | DW | Read data (zero when not driven) |
| dq_oe | output | 1 | Active-high drive enable for the data pins |

## Verification
The bench starts the counter from known rows using row-only cycles and walks it across the 1023-to-0 wrap, then checks the data with normal reads. If a design advanced the counter at the wrong time, or took the test row from the pins, the data would show up in the wrong row. One read-modify-write checks both that the old data is seen and that the new data lands in the same location. A design that kept driving after the write, or wrote to another row, would fail that check. Further checks cover the drive enable going low when the output enable or the row strobe goes high, and the aliasing of the dropped column bits.

// File: rtl/dram_cbr_test_ctrl.sv
module dram_cbr_test_ctrl #(
  parameter int ROW_W     = 10,
  parameter int MEM_COL_W = 1,
  parameter int DW        = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic [ROW_W-1:0] addr,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dq_out,
  output logic             dq_oe
);
  localparam int AW    = ROW_W + MEM_COL_W;
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_CBR, S_CHI, S_TEST} st_t;

  st_t              st;
  logic             ras_q, cas_q, we_q;
  logic [ROW_W-1:0] row_q, ctr;
  logic [AW-1:0]    acc_addr;
  logic             rd_phase, cas_seen;
  logic [DW-1:0]    rdata;
  logic [DW-1:0]    mem [DEPTH];

  wire ras_fall = ras_q & ~ras_n;
  wire ras_rise = ~ras_q & ras_n;
  wire cas_fall = cas_q & ~cas_n;
  wire cas_rise = ~cas_q & cas_n;
  wire we_fall  = we_q & ~we_n;

  wire             in_refresh = (st == S_CBR) || (st == S_CHI) || (st == S_TEST);
  wire             acc_now    = cas_fall && !ras_n && ((st == S_ROW) || (st == S_CHI));
  wire [ROW_W-1:0] acc_row    = (st == S_CHI) ? ctr : row_q;
  wire [AW-1:0]    new_addr   = {acc_row, addr[MEM_COL_W-1:0]};
  wire             wr_now     = (acc_now && !we_n) || (rd_phase && we_fall && !acc_now);
  wire [AW-1:0]    wr_addr    = acc_now ? new_addr : acc_addr;

  assign dq_oe  = rd_phase & ~oe_n;
  assign dq_out = dq_oe ? rdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      we_q  <= 1'b1;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      we_q  <= we_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      row_q    <= '0;
      ctr      <= '0;
      acc_addr <= '0;
      rd_phase <= 1'b0;
      cas_seen <= 1'b0;
    end else if (ras_rise) begin
      if (st == S_ROW && !cas_seen) ctr <= row_q;
      else if (in_refresh)          ctr <= ctr + 1'b1;
      st       <= S_IDLE;
      rd_phase <= 1'b0;
      cas_seen <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (ras_fall) begin
          st       <= cas_n ? S_ROW : S_CBR;
          row_q    <= addr;
          cas_seen <= 1'b0;
        end
        S_CBR:  if (cas_rise) st <= S_CHI;
        S_CHI:  if (acc_now)  st <= S_TEST;
        default: ;
      endcase
      if (acc_now) begin
        acc_addr <= new_addr;
        rd_phase <= we_n;
        if (st == S_ROW) cas_seen <= 1'b1;
      end else if (cas_rise || we_fall) begin
        rd_phase <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_now) mem[wr_addr] <= din;
    rdata <= mem[acc_addr];
  end

  assert_ctr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && in_refresh) |=> (ctr == $past(ctr) + 1'b1));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && ras_n && ras_q) |=> $stable(ctr));

  assert_ras_only_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_rise && st == S_ROW && !cas_seen) |=> (ctr == $past(row_q)));

  assert_test_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHI && cas_fall && !ras_n) |=> (acc_addr[AW-1:MEM_COL_W] == $past(ctr)));

  assert_hiz_after_ras_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ras_q && ras_n) |-> !dq_oe);

  assert_rmw_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_phase && we_fall && !acc_now) |=> !dq_oe);
endmodule

// File: tb/tb_dram_cbr_test_ctrl.sv
module tb_dram_cbr_test_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dq_out;
  logic dq_oe;
  int n_chk = 0, n_bad = 0;
  logic [3:0] got;

  always #5 clk = ~clk;

  dram_cbr_test_ctrl dut (.clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .oe_n(oe_n), .addr(addr), .din(din), .dq_out(dq_out), .dq_oe(dq_oe));

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic normal_write(input logic [9:0] r, input logic [9:0] c, input logic [3:0] d);
    addr = r; ras_n = 0; wait_n(2);
    addr = c; din = d; we_n = 0; cas_n = 0; wait_n(2);
    cas_n = 1; we_n = 1; ras_n = 1; wait_n(3);
  endtask

  task automatic normal_read(input logic [9:0] r, input logic [9:0] c, output logic [3:0] d, input string req);
    addr = r; ras_n = 0; wait_n(2);
    addr = c; we_n = 1; oe_n = 0; cas_n = 0; wait_n(4);
    d = dq_out;
    chk(req, {3'b0, dq_oe}, 4'h1);
    oe_n = 1; wait_n(1);
    chk("R10 oe high", {3'b0, dq_oe}, 4'h0);
    cas_n = 1; ras_n = 1; wait_n(3);
  endtask

  task automatic ras_only(input logic [9:0] r);
    addr = r; ras_n = 0; wait_n(3);
    ras_n = 1; wait_n(3);
  endtask

  task automatic cbr_refresh();
    cas_n = 0; wait_n(2);
    ras_n = 0; wait_n(2);
    chk("R2 refresh no drive", {3'b0, dq_oe}, 4'h0);
    ras_n = 1; wait_n(1);
    cas_n = 1; wait_n(3);
  endtask

  // mode 0 write, 1 read, 2 read-modify-write
  task automatic cbr_test(input logic [9:0] c, input int mode, input logic [3:0] wd, output logic [3:0] rd);
    cas_n = 0; wait_n(2);
    ras_n = 0; wait_n(2);
    cas_n = 1; wait_n(2);
    addr = c; din = wd; we_n = (mode == 0) ? 1'b0 : 1'b1; oe_n = (mode == 0) ? 1'b1 : 1'b0;
    cas_n = 0; wait_n(4);
    rd = dq_out;
    if (mode != 0) chk("R7 test read drives", {3'b0, dq_oe}, 4'h1);
    if (mode == 2) begin
      we_n = 0; wait_n(3);
      chk("R8 drive released after rmw write", {3'b0, dq_oe}, 4'h0);
    end
    ras_n = 1; we_n = 1; oe_n = 1; wait_n(1);
    cas_n = 1; wait_n(3);
  endtask

  task automatic t_reset();
    logic [3:0] r;
    chk("R1 reset dq_oe", {3'b0, dq_oe}, 4'h0);
    cbr_test(10'd0, 0, 4'h5, r);
    normal_read(10'd0, 10'd0, got, "R1 drive");
    chk("R1 counter starts at row 0", got, 4'h5);
  endtask

  task automatic t_normal();
    normal_write(10'd3, 10'd1, 4'hA);
    normal_write(10'd4, 10'd1, 4'h3);
    normal_read(10'd3, 10'd1, got, "R5 drive");
    chk("R4/R5 normal write then read", got, 4'hA);
    normal_read(10'd4, 10'd1, got, "R5 drive");
    chk("R4/R5 second location", got, 4'h3);
  endtask

  task automatic t_ras_only();
    logic [3:0] r;
    ras_only(10'd100);
    cbr_test(10'd0, 0, 4'h9, r);
    cbr_test(10'd0, 0, 4'h7, r);
    normal_read(10'd100, 10'd0, got, "R6 drive");
    chk("R3/R6 test write lands on loaded row", got, 4'h9);
    normal_read(10'd101, 10'd0, got, "R9 drive");
    chk("R9 counter advanced after test cycle", got, 4'h7);
  endtask

  task automatic t_refresh();
    logic [3:0] r;
    ras_only(10'd200);
    cbr_refresh();
    cbr_refresh();
    cbr_test(10'd1, 0, 4'hE, r);
    normal_read(10'd202, 10'd1, got, "R2 drive");
    chk("R2 two refreshes advance counter by two", got, 4'hE);
  endtask

  task automatic t_test_read();
    logic [3:0] r;
    normal_write(10'd300, 10'd1, 4'hC);
    ras_only(10'd300);
    cbr_test(10'd1, 1, 4'h0, r);
    chk("R7 test read from counter row", r, 4'hC);
  endtask

  task automatic t_rmw();
    logic [3:0] r;
    normal_write(10'd400, 10'd0, 4'h3);
    ras_only(10'd400);
    cbr_test(10'd0, 2, 4'hA, r);
    chk("R8 rmw reads old data", r, 4'h3);
    normal_read(10'd400, 10'd0, got, "R8 drive");
    chk("R8 rmw wrote same location", got, 4'hA);
  endtask

  task automatic t_wrap();
    logic [3:0] r;
    ras_only(10'd1023);
    cbr_test(10'd1, 0, 4'h1, r);
    cbr_test(10'd1, 0, 4'h2, r);
    normal_read(10'd1023, 10'd1, got, "R9 drive");
    chk("R9 row 1023 written", got, 4'h1);
    normal_read(10'd0, 10'd1, got, "R9 drive");
    chk("R9 counter wrapped to row 0", got, 4'h2);
  endtask

  task automatic t_alias_hiz();
    normal_write(10'd50, 10'd2, 4'h6);
    normal_read(10'd50, 10'd0, got, "R11 drive");
    chk("R11 column 2 aliases column 0", got, 4'h6);
    addr = 10'd50; ras_n = 0; wait_n(2);
    addr = 10'd0; oe_n = 0; cas_n = 0; wait_n(4);
    ras_n = 1; wait_n(2);
    chk("R10 no drive after ras high", {3'b0, dq_oe}, 4'h0);
    cas_n = 1; oe_n = 1; wait_n(3);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    wait_n(2);
    t_reset();
    t_normal();
    t_ras_only();
    t_refresh();
    t_test_read();
    t_rmw();
    t_wrap();
    t_alias_hiz();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule